// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a virtual address into a TLB fill entry after a TLB miss. It takes the virtual address and the translation table base when it is started. It fetches the first-level descriptor through a single-word read port. If that descriptor points to a coarse second-level table, it fetches the second-level descriptor through the same port. A walk ends in exactly one of two ways. Either it produces a fill entry (masked virtual address, masked physical address, permission bits, domain and mapping kind), or it produces a translation fault code together with the domain the walk touched.

The memory port is a request pulse followed by a response. The walker raises `mem_req_o` for one cycle with `mem_addr_o` valid. It then waits any number of cycles for `mem_rvalid_i`, which carries the descriptor on `mem_rdata_i`. The TLB array itself and the domain and permission checks sit outside this block. They consume the `done_o` / `fill_o` / `fault_o` result.

Top module: `xlat_walker`

## Requirements
- R1: After a synchronous reset, `busy_o`, `done_o`, `fill_o` and `mem_req_o` are low and `fault_o` is 00.
- R2: A `start_i` pulse while idle is followed in the next cycle by `mem_req_o` high and `busy_o` high. In that cycle `mem_addr_o` = (base & 0xFFFFC000) | (VA >> 18), with bits [1:0] zero.
- R3: A first-level descriptor with bits [1:0] equal to 00 or 11 ends the walk with `fault_o` = 01 (section fault). No fill strobe is raised and no second read is issued.
- R4: A first-level descriptor with bits [1:0] = 10 ends the walk with a fill. The outputs are: mapping kind 3 (section); PA = descriptor & 0xFFF00000; VA output = VA & 0xFFF00000; permissions = descriptor[11:0] & 0xC0C.
- R5: The reported domain is always bits [8:5] of the first-level descriptor, for fills and for both fault kinds.
- R6: A first-level descriptor with bits [1:0] = 01 causes a second read. Its address is (descriptor & 0xFFFFFC00) | ((VA & 0x000FF000) >> 10).
- R7: A second-level descriptor with bits [1:0] equal to 00 or 11 ends the walk with `fault_o` = 10 (page fault) and no fill strobe.
- R8: A second-level descriptor with bits [1:0] = 01 gives a fill with mapping kind 2 (large page). PA = descriptor & 0xFFFF0000, VA output = VA & 0xFFFF0000, and permissions = descriptor[11:0] & 0xFFC.
- R9: A second-level descriptor with bits [1:0] = 10 gives a fill with mapping kind 1 (small page). PA = descriptor & 0xFFFFF000, VA output = VA & 0xFFFFF000, and permissions = descriptor[11:0] & 0xFFC.
- R10: `done_o` is high for exactly one cycle per walk. `fill_o` is high exactly when `done_o` is high and `fault_o` is 00, and `fault_o` never reads 11 at `done_o`.
- R11: A `start_i` pulse while the walker is busy is ignored. The walk in progress completes with the first address's result, and no extra walk follows.
- R12: Each descriptor read raises `mem_req_o` for a single cycle. The walker waits for `mem_rvalid_i` for any number of cycles, so a section walk makes one request and a page walk makes two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a walk (honoured only when idle) |
| va_i | input | 32 | Virtual address to translate, sampled with start_i |
| ttb_i | input | 32 | Translation table base, sampled with start_i |
| mem_req_o | output | 1 | One-cycle descriptor read request |
| mem_addr_o | output | 32 | Descriptor word address |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response descriptor |
| busy_o | output | 1 | A walk is in progress |
| done_o | output | 1 | One-cycle walk completion |
| fill_o | output | 1 | Completion carries a valid fill entry |
| fault_o | output | 2 | 00 none, 01 section fault, 10 page fault |
| fill_va_o | output | 32 | Masked virtual address of the entry |
| fill_pa_o | output | 32 | Masked physical address of the entry |
| fill_perm_o | output | 12 | Permission bits of the entry |
| fill_dom_o | output | 4 | Domain of the entry or of the fault |
| fill_map_o | output | 2 | 0 none, 1 small page, 2 large page, 3 section |

## Verification
Walks are driven with first-level descriptors of all four low-bit codes, and second-level descriptors of all four low-bit codes. Each pairing separates a different exit of the state machine: section fault, section fill, page fault, large page or small page. The VA, base and descriptor values are chosen with dense, distinct bits in the index and masked fields, so a wrong shift, mask or alignment shows up as a wrong address or field. The response latency is varied from zero to several cycles, which distinguishes a walker that waits for the response from one that samples early. A start pulse inserted mid-walk shows whether a busy walker leaks a second request or adopts the new address.

// File: rtl/xw_pkg.sv
package xw_pkg;

  localparam int PERM_W = 12;
  localparam int DOM_W  = 4;

  typedef enum logic [1:0] {
    MAP_NONE    = 2'd0,
    MAP_SMALL   = 2'd1,
    MAP_LARGE   = 2'd2,
    MAP_SECTION = 2'd3
  } map_kind_t;

  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_SECTION = 2'd1,
    FLT_PAGE    = 2'd2
  } fault_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_DONE
  } walk_state_t;

  localparam logic [PERM_W-1:0] SECT_PERM_KEEP = 12'hC0C;
  localparam logic [PERM_W-1:0] PAGE_PERM_KEEP = 12'hFFC;

endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int L1_ALIGN   = 14,
  parameter int L2_ALIGN   = 10,
  parameter int SECT_SHIFT = 20,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [ADDR_W-1:0] ttb,
  input  logic [ADDR_W-1:0] va_now,
  input  logic [ADDR_W-1:0] va_held,
  input  logic [ADDR_W-1:0] l1_desc,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [ADDR_W-1:0] l2_addr
);

  // Table base bits, VA index bits and two zero bits must fill the word.
  localparam int L1_IDX_W = ADDR_W - SECT_SHIFT;
  localparam int L2_IDX_W = SECT_SHIFT - PAGE_SHIFT;

  assign l1_addr = {ttb[ADDR_W-1:L1_ALIGN], va_now[ADDR_W-1 -: L1_IDX_W], 2'b00};
  assign l2_addr = {l1_desc[ADDR_W-1:L2_ALIGN], va_held[PAGE_SHIFT +: L2_IDX_W], 2'b00};

  logic unused_addr_bits;
  assign unused_addr_bits = ^{ttb[L1_ALIGN-1:0], va_now[SECT_SHIFT-1:0],
                              l1_desc[L2_ALIGN-1:0], va_held[ADDR_W-1:SECT_SHIFT],
                              va_held[PAGE_SHIFT-1:0]};

endmodule

// File: rtl/xw_desc_decode.sv
module xw_desc_decode
  import xw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SECT_SHIFT  = 20,
  parameter int LARGE_SHIFT = 16,
  parameter int SMALL_SHIFT = 12,
  parameter int DOM_LSB     = 5
) (
  input  logic              second_level,
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output logic              is_fault,
  output logic              is_table,
  output map_kind_t         map,
  output logic [PERM_W-1:0] perm,
  output logic [DOM_W-1:0]  domain,
  output logic [ADDR_W-1:0] pa_out,
  output logic [ADDR_W-1:0] va_out
);

  localparam logic [ADDR_W-1:0] ONES       = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SECT_MASK  = ONES << SECT_SHIFT;
  localparam logic [ADDR_W-1:0] LARGE_MASK = ONES << LARGE_SHIFT;
  localparam logic [ADDR_W-1:0] SMALL_MASK = ONES << SMALL_SHIFT;

  logic [ADDR_W-1:0] keep;

  always_comb begin
    is_fault = 1'b0;
    is_table = 1'b0;
    map      = MAP_NONE;
    perm     = '0;
    keep     = '0;
    domain   = desc[DOM_LSB +: DOM_W];
    if (!second_level) begin
      unique case (desc[1:0])
        2'b10: begin
          map  = MAP_SECTION;
          keep = SECT_MASK;
          perm = desc[PERM_W-1:0] & SECT_PERM_KEEP;
        end
        2'b01:   is_table = 1'b1;
        default: is_fault = 1'b1;
      endcase
    end else begin
      unique case (desc[1:0])
        2'b01: begin
          map  = MAP_LARGE;
          keep = LARGE_MASK;
          perm = desc[PERM_W-1:0] & PAGE_PERM_KEEP;
        end
        2'b10: begin
          map  = MAP_SMALL;
          keep = SMALL_MASK;
          perm = desc[PERM_W-1:0] & PAGE_PERM_KEEP;
        end
        default: is_fault = 1'b1;
      endcase
    end
    pa_out = desc & keep;
    va_out = va & keep;
  end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int L1_ALIGN   = 14,
  parameter int L2_ALIGN   = 10,
  parameter int SECT_SHIFT = 20,
  parameter int PAGE_SHIFT = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic [ADDR_W-1:0] ttb_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [ADDR_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fill_o,
  output logic [1:0]        fault_o,
  output logic [ADDR_W-1:0] fill_va_o,
  output logic [ADDR_W-1:0] fill_pa_o,
  output logic [PERM_W-1:0] fill_perm_o,
  output logic [DOM_W-1:0]  fill_dom_o,
  output logic [1:0]        fill_map_o
);

  walk_state_t       state_q;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] addr_q;
  fault_t            fault_q;
  map_kind_t         map_q;
  logic [ADDR_W-1:0] va_out_q;
  logic [ADDR_W-1:0] pa_q;
  logic [PERM_W-1:0] perm_q;
  logic [DOM_W-1:0]  dom_q;

  logic [ADDR_W-1:0] l1_addr, l2_addr;
  logic              dec_fault, dec_table;
  map_kind_t         dec_map;
  logic [PERM_W-1:0] dec_perm;
  logic [DOM_W-1:0]  dec_dom;
  logic [ADDR_W-1:0] dec_pa, dec_va;

  xw_addr_gen #(
    .ADDR_W(ADDR_W), .L1_ALIGN(L1_ALIGN), .L2_ALIGN(L2_ALIGN),
    .SECT_SHIFT(SECT_SHIFT), .PAGE_SHIFT(PAGE_SHIFT)
  ) u_addr (
    .ttb(ttb_i), .va_now(va_i), .va_held(va_q), .l1_desc(mem_rdata_i),
    .l1_addr(l1_addr), .l2_addr(l2_addr)
  );

  xw_desc_decode #(
    .ADDR_W(ADDR_W), .SECT_SHIFT(SECT_SHIFT), .SMALL_SHIFT(PAGE_SHIFT)
  ) u_dec (
    .second_level(state_q == ST_L2_WAIT), .desc(mem_rdata_i), .va(va_q),
    .is_fault(dec_fault), .is_table(dec_table), .map(dec_map), .perm(dec_perm),
    .domain(dec_dom), .pa_out(dec_pa), .va_out(dec_va)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      va_q     <= '0;
      addr_q   <= '0;
      fault_q  <= FLT_NONE;
      map_q    <= MAP_NONE;
      va_out_q <= '0;
      pa_q     <= '0;
      perm_q   <= '0;
      dom_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          va_q    <= va_i;
          addr_q  <= l1_addr;
          state_q <= ST_L1_REQ;
        end
        ST_L1_REQ: state_q <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rvalid_i) begin
          dom_q <= dec_dom;
          if (dec_table) begin
            addr_q  <= l2_addr;
            state_q <= ST_L2_REQ;
          end else begin
            fault_q  <= dec_fault ? FLT_SECTION : FLT_NONE;
            map_q    <= dec_map;
            pa_q     <= dec_pa;
            va_out_q <= dec_va;
            perm_q   <= dec_perm;
            state_q  <= ST_DONE;
          end
        end
        ST_L2_REQ: state_q <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rvalid_i) begin
          fault_q  <= dec_fault ? FLT_PAGE : FLT_NONE;
          map_q    <= dec_map;
          pa_q     <= dec_pa;
          va_out_q <= dec_va;
          perm_q   <= dec_perm;
          state_q  <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign mem_addr_o  = addr_q;
  assign done_o      = (state_q == ST_DONE);
  assign fill_o      = done_o && (fault_q == FLT_NONE);
  assign fault_o     = fault_q;
  assign fill_va_o   = va_out_q;
  assign fill_pa_o   = pa_q;
  assign fill_perm_o = perm_q;
  assign fill_dom_o  = dom_q;
  assign fill_map_o  = map_q;

  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  a_r10_fill_no_fault: assert property (@(posedge clk) disable iff (rst)
    fill_o |-> (fault_o == FLT_NONE) && (fill_map_o != MAP_NONE));

  a_r10_code_legal: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (fault_o != 2'b11));

  a_r12_req_single: assert property (@(posedge clk) disable iff (rst)
    mem_req_o |=> !mem_req_o);

  a_r2_walk_opens_with_req: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> mem_req_o);

  a_r4_section_aligned: assert property (@(posedge clk) disable iff (rst)
    (fill_o && fill_map_o == MAP_SECTION) |-> (fill_pa_o[SECT_SHIFT-1:0] == '0));

endmodule

// File: tb/xlat_walker_bench.sv
module xlat_walker_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic [31:0] va_i, ttb_i;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        busy_o, done_o, fill_o;
  logic [1:0]  fault_o;
  logic [31:0] fill_va_o, fill_pa_o;
  logic [11:0] fill_perm_o;
  logic [3:0]  fill_dom_o;
  logic [1:0]  fill_map_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rst(rst), .start_i(start_i), .va_i(va_i), .ttb_i(ttb_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .done_o(done_o), .fill_o(fill_o), .fault_o(fault_o),
    .fill_va_o(fill_va_o), .fill_pa_o(fill_pa_o), .fill_perm_o(fill_perm_o),
    .fill_dom_o(fill_dom_o), .fill_map_o(fill_map_o)
  );

  int n_chk  = 0;
  int n_fail = 0;

  // Memory model state: main block writes the walk setup, responder owns the log.
  int          lat;
  int          walk_base;
  logic [31:0] l1_data, l2_data;
  int          req_count;
  logic [31:0] req_log [4];

  initial begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = 32'hFFFF_FFFF;
    req_count    = 0;
    forever begin
      @(negedge clk);
      while (mem_req_o) begin
        int idx;
        logic [31:0] d;
        idx = req_count - walk_base;
        req_log[idx & 3] = mem_addr_o;
        d = (idx == 0) ? l1_data : l2_data;
        req_count++;
        @(negedge clk);
        repeat (lat) @(negedge clk);
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = d;
        @(negedge clk);
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = 32'hFFFF_FFFF;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] x_l1(input logic [31:0] va, ttb);
    return ((ttb & 32'hFFFF_C000) | (va >> 18)) & ~32'h3;
  endfunction
  function automatic logic [31:0] x_l2(input logic [31:0] d1, va);
    return ((d1 & 32'hFFFF_FC00) | ((va & 32'h000F_F000) >> 10)) & ~32'h3;
  endfunction
  function automatic logic [3:0] x_dom(input logic [31:0] d1);
    return 4'((d1 >> 5) & 32'hF);
  endfunction

  // Captured results of the most recent walk.
  logic        g_req_first, g_busy_first, g_timeout, g_done_next, g_idle_busy;
  logic        g_fill;
  logic [1:0]  g_fault, g_map;
  logic [3:0]  g_dom;
  logic [11:0] g_perm;
  logic [31:0] g_va, g_pa, g_a0, g_a1;
  int          g_nreq, g_nreq_after;

  task automatic do_walk(input logic [31:0] va, ttb, d1, d2, input int lat_cyc,
                         input int poke, input logic [31:0] va2);
    int cyc;
    lat = lat_cyc; l1_data = d1; l2_data = d2; walk_base = req_count;
    req_log[0] = 32'h0; req_log[1] = 32'h0;
    @(negedge clk);
    start_i = 1'b1; va_i = va; ttb_i = ttb;
    @(negedge clk);
    start_i = 1'b0; va_i = 32'h0;
    g_req_first = mem_req_o; g_busy_first = busy_o;
    cyc = 0; g_timeout = 1'b0;
    while (!done_o) begin
      if (cyc >= 300) begin g_timeout = 1'b1; break; end
      @(negedge clk);
      cyc++;
      start_i = (poke != 0) && (cyc == poke);
      if (start_i) va_i = va2;
    end
    start_i = 1'b0;
    g_fill = fill_o; g_fault = fault_o; g_map = fill_map_o; g_dom = fill_dom_o;
    g_perm = fill_perm_o; g_va = fill_va_o; g_pa = fill_pa_o;
    g_nreq = req_count - walk_base; g_a0 = req_log[0]; g_a1 = req_log[1];
    @(negedge clk);
    g_done_next = done_o;
    repeat (4) @(negedge clk);
    g_idle_busy = busy_o;
    g_nreq_after = req_count - walk_base;
    chk(!g_timeout, "R12 walk completes", 32'(g_timeout), 32'h0);
    chk(g_req_first && g_busy_first, "R2 request follows start", 32'(g_req_first), 32'h1);
    chk(g_a0 == x_l1(va, ttb), "R2 first-level address", g_a0, x_l1(va, ttb));
    chk(!g_done_next, "R10 done lasts one cycle", 32'(g_done_next), 32'h0);
    chk(g_fill == (g_fault == 2'b00), "R10 fill iff no fault", 32'(g_fill), 32'(g_fault == 2'b00));
    chk(g_dom == x_dom(d1), "R5 domain from first level", 32'(g_dom), 32'(x_dom(d1)));
    chk(!g_idle_busy && g_nreq_after == g_nreq, "R11 idle after walk",
        32'(g_nreq_after), 32'(g_nreq));
  endtask

  task automatic t_reset;
    rst = 1'b1; start_i = 1'b0; va_i = '0; ttb_i = '0;
    lat = 0; walk_base = 0; l1_data = '0; l2_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !done_o && !fill_o && !mem_req_o && fault_o == 2'b00,
        "R1 reset state", {27'h0, busy_o, done_o, fill_o, mem_req_o, 1'b0}, 32'h0);
  endtask

  task automatic t_section_fault(input logic [31:0] d1);
    do_walk(32'hCAFE_1234, 32'h0123_7FFF, d1, 32'h0, 1, 0, 32'h0);
    chk(g_fault == 2'b01 && !g_fill, "R3 section fault code", 32'(g_fault), 32'h1);
    chk(g_nreq == 1, "R3 no second read", 32'(g_nreq), 32'h1);
  endtask

  task automatic t_section;
    logic [31:0] va, d1;
    va = 32'h1234_5678; d1 = 32'hABC5_5DEE;
    do_walk(va, 32'h0008_4ABC, d1, 32'h0, 0, 0, 32'h0);
    chk(g_fill && g_map == 2'd3, "R4 section kind", 32'(g_map), 32'h3);
    chk(g_pa == (d1 & 32'hFFF0_0000), "R4 section pa", g_pa, d1 & 32'hFFF0_0000);
    chk(g_va == (va & 32'hFFF0_0000), "R4 section va", g_va, va & 32'hFFF0_0000);
    chk(g_perm == (d1[11:0] & 12'hC0C), "R4 section perm", 32'(g_perm), 32'(d1[11:0] & 12'hC0C));
    chk(g_nreq == 1, "R12 one request for section", 32'(g_nreq), 32'h1);
  endtask

  task automatic t_page(input logic [31:0] d2, input int lat_cyc, input logic [1:0] kind,
                        input logic [31:0] keep, input string tag);
    logic [31:0] va, d1;
    va = 32'h9ABC_DEF4; d1 = 32'h3C00_41A1;
    do_walk(va, 32'hFFFF_0123, d1, d2, lat_cyc, 0, 32'h0);
    chk(g_nreq == 2, "R12 two requests for page", 32'(g_nreq), 32'h2);
    chk(g_a1 == x_l2(d1, va), "R6 second-level address", g_a1, x_l2(d1, va));
    chk(g_fill && g_map == kind, {tag, " kind"}, 32'(g_map), 32'(kind));
    chk(g_pa == (d2 & keep), {tag, " pa"}, g_pa, d2 & keep);
    chk(g_va == (va & keep), {tag, " va"}, g_va, va & keep);
    chk(g_perm == (d2[11:0] & 12'hFFC), {tag, " perm"}, 32'(g_perm), 32'(d2[11:0] & 12'hFFC));
  endtask

  task automatic t_page_fault(input logic [31:0] d2);
    logic [31:0] d1;
    d1 = 32'h5555_51E1;
    do_walk(32'h0F0F_A5A5, 32'h4000_0000, d1, d2, 2, 0, 32'h0);
    chk(g_fault == 2'b10 && !g_fill, "R7 page fault code", 32'(g_fault), 32'h2);
    chk(g_nreq == 2, "R7 fault after second read", 32'(g_nreq), 32'h2);
  endtask

  task automatic t_busy_start;
    logic [31:0] va, d1, d2;
    va = 32'h7654_3210; d1 = 32'h0011_2261; d2 = 32'hFEDC_BA9A;
    do_walk(va, 32'h00A0_0000, d1, d2, 2, 2, 32'hFFFF_FFFF);
    chk(g_nreq == 2 && g_a0 == x_l1(va, 32'h00A0_0000), "R11 busy start ignored",
        g_a0, x_l1(va, 32'h00A0_0000));
    chk(g_va == (va & 32'hFFFF_F000) && g_map == 2'd1, "R11 first walk result kept",
        g_va, va & 32'hFFFF_F000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_section_fault(32'hFFFF_FFE0);
    t_section_fault(32'h0000_01E3);
    t_section();
    t_page(32'h7654_3FF5, 1, 2'd2, 32'hFFFF_0000, "R8 large page");
    t_page(32'h0ABC_D556, 3, 2'd1, 32'hFFFF_F000, "R9 small page");
    t_page_fault(32'h1234_5670);
    t_page_fault(32'h1234_5673);
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule